// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

The aggregator merges level-sensitive interrupt requests from a set of device slots onto a small number of shared interrupt lines. Every slot has four request pins. Each pin is assigned to one shared line by a fixed routing rule. A line is driven high while at least one of the pins assigned to it is asserted.

The block does not OR the pins together. It keeps a copy of the last level seen on every pin. Each clock it compares the incoming levels with that copy and turns every difference into a +1 or -1 step for the counter of the pin's line. A line output is high when its counter is nonzero. Pin levels are sampled on every clock edge. There is no handshake, because the pins are plain levels. Reset is synchronous and active high.

Top module: `irq_line_aggregator`

## Requirements
- R1: While reset is asserted, every counter and every remembered pin level is cleared. In the cycle after a reset edge all lines are low. A pin held high through reset counts as a fresh assertion at the first edge after reset is released.
- R2: If any pin routed to a line is sampled high at a clock edge, that line is high after that edge.
- R3: Pin p (0 to 3) of slot s is bit s*4+p of `pin_lvl` and is routed to line (s + p) mod NUM_LINES.
- R4: If all pins routed to a line are sampled low at a clock edge, that line is low after that edge.
- R5: Any number of pins may change in the same cycle, including pins on the same line moving in opposite directions. All their steps are applied at that edge and none is lost.
- R6: A pin sampled at the same level as its remembered level has no effect. If every pin is unchanged, the lines keep their values.
- R7: A line counter never drops below zero. It never exceeds the number of pins routed to its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | NUM_SLOTS*4 | Request pin levels, bit s*4+p is pin p of slot s |
| irq_line | output | NUM_LINES | Shared interrupt line levels |

## Verification
The hardest case to reach is counter drift. It appears when one pin on a line rises in the same cycle that another pin on the same line falls. The OR of the pins is unchanged in that cycle, so the error stays hidden until the last remaining source drops and the line fails to fall. The stimulus builds such swaps on purpose from two pins that share a line. It also flips all pins at once in both directions, and adds long runs of sparse random changes. A behavioural model with integer counters is compared against the outputs every cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int PINS_PER_SLOT = 4;

  // routing rule: (slot + pin) mod number of lines
  function automatic int route_line(input int slot, input int pin, input int lines);
    return (slot + pin) % lines;
  endfunction
endpackage

// File: rtl/irqagg_level_track.sv
module irqagg_level_track #(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl_in,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= lvl_in;
  end

  assign rise_o =  lvl_in & ~seen_q;
  assign fall_o = ~lvl_in &  seen_q;
endmodule

// File: rtl/irqagg_line_cnt.sv
module irqagg_line_cnt
  import irqagg_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_LINES = 4,
  parameter int CW        = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise_i,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall_i,
  output logic [NUM_LINES*CW-1:0]           cnt_o,
  output logic [NUM_LINES-1:0]              line_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] up_c;
    logic [CW-1:0] dn_c;

    always_comb begin
      up_c = '0;
      dn_c = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS_PER_SLOT; p++) begin
          if (route_line(s, p, NUM_LINES) == l) begin
            up_c = up_c + CW'(rise_i[s*PINS_PER_SLOT+p]);
            dn_c = dn_c + CW'(fall_i[s*PINS_PER_SLOT+p]);
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + up_c - dn_c;
    end

    assign cnt_o[l*CW +: CW] = cnt_q;
    assign line_o[l]         = |cnt_q;
  end
endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_LINES = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_lvl,
  output logic [NUM_LINES-1:0]               irq_line
);
  localparam int NPINS = NUM_SLOTS * PINS_PER_SLOT;
  localparam int CW    = $clog2(NPINS + 1);

  logic [NPINS-1:0]        rise_w;
  logic [NPINS-1:0]        fall_w;
  logic [NUM_LINES*CW-1:0] cnt_flat;

  irqagg_level_track #(.NUM_PINS(NPINS)) track_i (
    .clk    (clk),
    .rst    (rst),
    .lvl_in (pin_lvl),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  irqagg_line_cnt #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_LINES (NUM_LINES),
    .CW        (CW)
  ) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .cnt_o  (cnt_flat),
    .line_o (irq_line)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_LINES = 4,
  parameter int CW        = 8
) (
  input logic                               clk,
  input logic                               rst,
  input logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_lvl,
  input logic [NUM_LINES-1:0]               irq_line,
  input logic [NUM_LINES*CW-1:0]            cnt_flat
);
  localparam int NPINS = NUM_SLOTS * PINS_PER_SLOT;

  function automatic logic [NPINS-1:0] line_mask(input int l);
    logic [NPINS-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < PINS_PER_SLOT; p++)
        if (route_line(s, p, NUM_LINES) == l) m[s*PINS_PER_SLOT+p] = 1'b1;
    return m;
  endfunction

  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> irq_line == '0);

  // R6
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && pin_lvl == $past(pin_lvl)) |=> $stable(irq_line));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    localparam logic [NPINS-1:0] MASK = line_mask(l);
    localparam int PER_LINE = $countones(MASK);

    // R2
    line_high_chk: assert property (@(posedge clk) disable iff (rst)
      (|(pin_lvl & MASK)) |=> irq_line[l]);

    // R4
    line_low_chk: assert property (@(posedge clk) disable iff (rst)
      !(|(pin_lvl & MASK)) |=> !irq_line[l]);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[l*CW +: CW] <= CW'(PER_LINE));
  end
endmodule

bind irq_line_aggregator irqagg_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .NUM_LINES (NUM_LINES),
  .CW        (CW)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .pin_lvl  (pin_lvl),
  .irq_line (irq_line),
  .cnt_flat (cnt_flat)
);

// File: tb/irq_line_aggregator_tb.sv
module irq_line_aggregator_tb_top;
  localparam int CLK_P  = 10;
  localparam int SLOTS  = 32;
  localparam int LINES  = 4;
  localparam int NPINS  = SLOTS * 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NPINS-1:0] pin_lvl = '0;
  logic [LINES-1:0] irq_line;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int cnt_m [LINES];
  bit seen_m [NPINS];
  logic [LINES-1:0] exp_line;

  irq_line_aggregator #(.NUM_SLOTS(SLOTS), .NUM_LINES(LINES)) dut_i (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .irq_line(irq_line)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: integer counters and remembered levels
  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LINES; l++) cnt_m[l] = 0;
      for (int i = 0; i < NPINS; i++) seen_m[i] = 0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (pin_lvl[i] != seen_m[i]) begin
          cnt_m[((i / 4) + (i % 4)) % LINES] += pin_lvl[i] ? 1 : -1;
          seen_m[i] = pin_lvl[i];
        end
      end
    end
    for (int l = 0; l < LINES; l++) exp_line[l] = (cnt_m[l] != 0);
  end

  task automatic step(input string tag);
    @(negedge clk);
    total++;
    if (irq_line !== exp_line) begin
      bad++;
      $display("FAIL %s: irq_line=%b expected=%b", tag, irq_line, exp_line);
    end
  endtask

  task automatic check_val(input string tag, input logic [LINES-1:0] want);
    total++;
    if (irq_line !== want) begin
      bad++;
      $display("FAIL %s: irq_line=%b expected=%b", tag, irq_line, want);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with every pin high
    pin_lvl = '1;
    repeat (3) step("R1 reset");
    check_val("R1 lines low in reset", '0);
    rst = 1'b0;
    step("R1 first edge after reset");
    check_val("R1 held pin counts as new", '1);
    pin_lvl = '0;
    step("R1 release");
    check_val("R1 all low", '0);

    // R3: walk one pin at a time
    for (int i = 0; i < NPINS; i++) begin
      pin_lvl = '0;
      pin_lvl[i] = 1'b1;
      step("R3 walk");
      check_val("R3 routing", LINES'(1) << (((i / 4) + (i % 4)) % LINES));
    end
    pin_lvl = '0;
    step("R4 walk end");
    check_val("R4 all low", '0);

    // R5: opposite moves on one line in a single cycle
    pin_lvl[0] = 1'b1;               // slot0 pin0 -> line0
    step("R5 setup");
    pin_lvl[0] = 1'b0;
    pin_lvl[1*4+3] = 1'b1;           // slot1 pin3 -> line0
    step("R5 swap");
    check_val("R5 swap keeps line", 4'b0001);
    pin_lvl[1*4+3] = 1'b0;
    step("R5 last drop");
    check_val("R5 line falls", '0);

    // R5: all pins rise together, then all but one fall together
    pin_lvl = '1;
    step("R5 all rise");
    pin_lvl = '0;
    pin_lvl[2*4+1] = 1'b1;           // slot2 pin1 -> line3
    step("R5 mass fall");
    check_val("R5 one survivor", 4'b1000);

    // R6: hold steady
    repeat (20) step("R6 hold");
    check_val("R6 unchanged", 4'b1000);
    pin_lvl = '0;
    step("R4 drop");

    // R2 R4 R5 R7: sparse random toggles
    for (int c = 0; c < 4000; c++) begin
      int k;
      k = $urandom_range(3);
      for (int j = 0; j < k; j++) begin
        int b;
        b = $urandom_range(NPINS - 1);
        pin_lvl[b] = ~pin_lvl[b];
      end
      if ($urandom_range(49) == 0) pin_lvl = '0;
      step("R2 R4 random");
    end

    // R1: reset in the middle of activity
    pin_lvl = '1;
    step("R1 busy");
    rst = 1'b1;
    step("R1 mid reset");
    check_val("R1 mid reset low", '0);
    rst = 1'b0;
    pin_lvl = '0;
    step("R1 after mid reset");
    check_val("R1 stays low", '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule